// File: doc/BRIEF.md
# USB endpoint FIFO access controller

This block sits between firmware and the buffer memory of a USB device. Firmware uses it to claim the FIFO of one endpoint, move data through it, and mark the end of the transfer. Firmware works through a single command/status register. Writing that register starts a claim, selects the transfer direction and requests a flush. Reading it returns the claim state and three per-endpoint flags: a SETUP packet is waiting, the host sent a zero-byte packet, and the FIFO is ready.

A transfer is a two-phase handshake. Firmware picks an endpoint on `ep_sel` and sets the request bit. During a write it holds the direction bit at 1 and ends the transfer by returning it to 0. During a read it holds the bit at 0 and ends the transfer by raising it to 1. Either end edge produces a one-cycle commit pulse to the FIFO datapath. A write commit carries the byte count gathered during the claim. A read commit frees the buffer.

A flush empties the chosen FIFO at once. It also arms that endpoint so that the next host IN is answered with a forced transmit error, which tells the host the data ran short. A USB bus reset returns all of the block's state to zero.

Top module: `ep_fifo_access_ctrl`

## Requirements
- R1: A cycle with `usb_rst` high clears all of the following: the claim, the direction bit, every per-endpoint setup, zero-length and flush-pending flag, and the pulse outputs. Afterwards a host IN is not forced to error.
- R2: The register layout is: bit 0 request, bit 1 direction (1 = firmware writes), bit 2 flush, bit 3 setup, bit 4 ready, bit 5 zero-length. A register write that sets bit 0 while no claim is held raises `fifo_req` after that edge. It also sets `fifo_ep` to the `ep_sel` value of that write and `fifo_dir` to bit 1 of that write.
- R3: In a claim opened with direction 1, a write that keeps the claim and moves the direction bit from 1 to 0 produces `commit_wr` for exactly one cycle after that edge. `commit_cnt` then holds the number of `cpu_byte_stb` cycles seen during the claim, saturating at 2^CNT_W-1.
- R4: In a claim opened with direction 0, a write that moves the direction bit from 0 to 1 produces `commit_rd` for one cycle and clears the zero-length flag of the claimed endpoint.
- R5: A claim produces at most one commit. Later direction toggles produce no pulse until the request bit is dropped.
- R6: Writing bit 0 = 1 while a claim is held changes neither `fifo_ep` nor the byte count, even if `ep_sel` has changed.
- R7: Writing bit 0 = 0 ends the claim, and `fifo_req` is low after that edge.
- R8: Writing bit 2 = 1 gives a one-cycle `fifo_clr` with `clr_ep` equal to `ep_sel`, whatever the ready state. Bit 2 always reads as 0.
- R9: After a flush of endpoint E, the next `host_in_stb` to E gives a one-cycle `force_tx_err`. Later INs to E, and INs to other endpoints, give none.
- R10: A setup strobe sets bit 3 for its endpoint. The bit holds until a data or zero-length strobe arrives for that same endpoint. Strobes for other endpoints leave it unchanged.
- R11: Bit 4 reads `sie_ready[ep_sel]` and does not depend on register writes.
- R12: A zero-length strobe sets bit 5 for its endpoint. Bits 7:6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| usb_rst | input | 1 | USB bus reset, synchronous clear |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data for the selected endpoint |
| ep_sel | input | EP_W | Endpoint chosen by firmware |
| cpu_byte_stb | input | 1 | One FIFO byte moved by firmware |
| sie_ep | input | EP_W | Endpoint of the serial-engine event |
| sie_setup_stb | input | 1 | SETUP packet stored |
| sie_data_stb | input | 1 | Non-setup data packet stored |
| sie_zlp_stb | input | 1 | Zero-byte OUT packet received |
| sie_ready | input | 2^EP_W | Per-endpoint FIFO ready levels |
| host_in_stb | input | 1 | Host IN token seen |
| host_in_ep | input | EP_W | Endpoint of the IN token |
| fifo_req | output | 1 | Claim held |
| fifo_dir | output | 1 | Current direction bit |
| fifo_ep | output | EP_W | Claimed endpoint |
| commit_wr | output | 1 | Write transfer end pulse |
| commit_rd | output | 1 | Read transfer end pulse |
| commit_cnt | output | CNT_W | Byte count of the last write commit |
| fifo_clr | output | 1 | Flush pulse |
| clr_ep | output | EP_W | Endpoint being flushed |
| force_tx_err | output | 1 | Forced underrun reply pulse |

## Verification
The hardest case to reach from the ports is a stale claim. A second request that names another endpoint arrives while the first claim is still open, and byte strobes come both before and after it, so the bench must see that neither the claimed endpoint nor the running count moves. A directed sequence builds exactly that interleaving and then checks the commit count. The direction toggles that follow a commit are driven the same way, so the one-commit rule is exercised. Random rounds then mix flushes, host INs and serial-engine events over all endpoints against a per-endpoint model. This reaches flush-then-IN orderings and sticky setup states that directed tests alone would miss.

// File: rtl/efa_pkg.sv
package efa_pkg;
  localparam int BIT_REQ   = 0;
  localparam int BIT_DIR   = 1;
  localparam int BIT_CLR   = 2;
  localparam int BIT_SETUP = 3;
  localparam int BIT_READY = 4;
  localparam int BIT_ZLEN  = 5;

  typedef enum logic [1:0] {
    XFER_IDLE   = 2'd0,
    XFER_ACTIVE = 2'd1,
    XFER_DONE   = 2'd2
  } xfer_st_e;

  // saturating increment used by the byte counter
  function automatic int unsigned efa_sat_inc(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? cur : cur + 1;
  endfunction
endpackage

// File: rtl/efa_handshake.sv
module efa_handshake
  import efa_pkg::*;
#(
  parameter int EP_W  = 3,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             usb_rst,
  input  logic             wr_stb,
  input  logic             wr_req,
  input  logic             wr_dir,
  input  logic [EP_W-1:0]  ep_sel,
  input  logic             byte_stb,
  output logic             req_active,
  output logic             dir_q,
  output logic [EP_W-1:0]  xfer_ep,
  output logic             commit_wr,
  output logic             commit_rd,
  output logic [CNT_W-1:0] commit_cnt,
  output logic             rd_done_stb,
  output logic [EP_W-1:0]  rd_done_ep
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  xfer_st_e         st_q;
  logic             mode_wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             commit_wr_q, commit_rd_q;
  logic [CNT_W-1:0] commit_cnt_q;

  // named transfer-end events
  logic grant_evt, end_wr_evt, end_rd_evt, drop_evt;
  assign grant_evt  = wr_stb && wr_req && (st_q == XFER_IDLE);
  assign end_wr_evt = wr_stb && (st_q == XFER_ACTIVE) && mode_wr_q && dir_q && !wr_dir;
  assign end_rd_evt = wr_stb && (st_q == XFER_ACTIVE) && !mode_wr_q && !dir_q && wr_dir;
  assign drop_evt   = wr_stb && !wr_req && (st_q != XFER_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= XFER_IDLE;
      mode_wr_q    <= 1'b0;
      dir_q        <= 1'b0;
      xfer_ep      <= '0;
      cnt_q        <= '0;
      commit_wr_q  <= 1'b0;
      commit_rd_q  <= 1'b0;
      commit_cnt_q <= '0;
    end else if (usb_rst) begin
      st_q         <= XFER_IDLE;
      mode_wr_q    <= 1'b0;
      dir_q        <= 1'b0;
      xfer_ep      <= '0;
      cnt_q        <= '0;
      commit_wr_q  <= 1'b0;
      commit_rd_q  <= 1'b0;
      commit_cnt_q <= '0;
    end else begin
      commit_wr_q <= end_wr_evt;
      commit_rd_q <= end_rd_evt;
      if (end_wr_evt) commit_cnt_q <= cnt_q;
      if (wr_stb) dir_q <= wr_dir;
      if (grant_evt) begin
        st_q      <= XFER_ACTIVE;
        xfer_ep   <= ep_sel;
        mode_wr_q <= wr_dir;
        cnt_q     <= '0;
      end else if (st_q != XFER_IDLE) begin
        if (byte_stb) cnt_q <= CNT_W'(efa_sat_inc(32'(cnt_q), CNT_MAX));
        if (drop_evt) st_q <= XFER_IDLE;
        else if (end_wr_evt || end_rd_evt) st_q <= XFER_DONE;
      end
    end
  end

  assign req_active  = (st_q != XFER_IDLE);
  assign commit_wr   = commit_wr_q;
  assign commit_rd   = commit_rd_q;
  assign commit_cnt  = commit_cnt_q;
  assign rd_done_stb = end_rd_evt;
  assign rd_done_ep  = xfer_ep;

  AST_COMMIT_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_wr |=> !commit_wr); // R3
  AST_COMMIT_RD_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_rd |-> $past(req_active)); // R4
  AST_ONE_COMMIT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_wr, commit_rd})); // R5
  AST_EP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_active && $past(req_active)) |-> $stable(xfer_ep)); // R6
endmodule

// File: rtl/efa_ep_status.sv
module efa_ep_status #(
  parameter int EP_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   usb_rst,
  input  logic [EP_W-1:0]        sie_ep,
  input  logic                   setup_stb,
  input  logic                   data_stb,
  input  logic                   zlp_stb,
  input  logic                   rd_done_stb,
  input  logic [EP_W-1:0]        rd_done_ep,
  input  logic                   clr_stb,
  input  logic [EP_W-1:0]        clr_ep,
  input  logic                   host_in_stb,
  input  logic [EP_W-1:0]        host_in_ep,
  output logic [(1<<EP_W)-1:0]   setup_vec,
  output logic [(1<<EP_W)-1:0]   zlen_vec,
  output logic                   force_tx_err
);
  localparam int NUM_EP = 1 << EP_W;

  logic [NUM_EP-1:0] setup_q, zlen_q, pend_q;
  logic              force_q;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic hit_sie, hit_rd, hit_clr, hit_in;
    assign hit_sie = (sie_ep == EP_W'(e));
    assign hit_rd  = rd_done_stb && (rd_done_ep == EP_W'(e));
    assign hit_clr = clr_stb && (clr_ep == EP_W'(e));
    assign hit_in  = host_in_stb && (host_in_ep == EP_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        setup_q[e] <= 1'b0;
        zlen_q[e]  <= 1'b0;
        pend_q[e]  <= 1'b0;
      end else if (usb_rst) begin
        setup_q[e] <= 1'b0;
        zlen_q[e]  <= 1'b0;
        pend_q[e]  <= 1'b0;
      end else begin
        if (hit_sie && setup_stb) setup_q[e] <= 1'b1;
        else if (hit_sie && (data_stb || zlp_stb)) setup_q[e] <= 1'b0;
        if (hit_sie && zlp_stb) zlen_q[e] <= 1'b1;
        else if (hit_rd) zlen_q[e] <= 1'b0;
        if (hit_clr) pend_q[e] <= 1'b1;
        else if (hit_in) pend_q[e] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       force_q <= 1'b0;
    else if (usb_rst) force_q <= 1'b0;
    else              force_q <= host_in_stb && pend_q[host_in_ep];
  end

  assign setup_vec    = setup_q;
  assign zlen_vec     = zlen_q;
  assign force_tx_err = force_q;

  AST_ZLEN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done_stb && !usb_rst && !(zlp_stb && sie_ep == rd_done_ep)) |=> !zlen_q[$past(rd_done_ep)]); // R4
  AST_FORCE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (force_tx_err && !$past(clr_stb && (clr_ep == host_in_ep))) |-> !pend_q[$past(host_in_ep)]); // R9
endmodule

// File: rtl/ep_fifo_access_ctrl.sv
module ep_fifo_access_ctrl
  import efa_pkg::*;
#(
  parameter int EP_W  = 3,
  parameter int CNT_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 usb_rst,
  input  logic                 cpu_wr,
  input  logic [7:0]           cpu_wdata,
  output logic [7:0]           cpu_rdata,
  input  logic [EP_W-1:0]      ep_sel,
  input  logic                 cpu_byte_stb,
  input  logic [EP_W-1:0]      sie_ep,
  input  logic                 sie_setup_stb,
  input  logic                 sie_data_stb,
  input  logic                 sie_zlp_stb,
  input  logic [(1<<EP_W)-1:0] sie_ready,
  input  logic                 host_in_stb,
  input  logic [EP_W-1:0]      host_in_ep,
  output logic                 fifo_req,
  output logic                 fifo_dir,
  output logic [EP_W-1:0]      fifo_ep,
  output logic                 commit_wr,
  output logic                 commit_rd,
  output logic [CNT_W-1:0]     commit_cnt,
  output logic                 fifo_clr,
  output logic [EP_W-1:0]      clr_ep,
  output logic                 force_tx_err
);
  localparam int NUM_EP = 1 << EP_W;

  logic              wr_req, wr_dir, wr_clr;
  logic              rd_done_stb;
  logic [EP_W-1:0]   rd_done_ep;
  logic [NUM_EP-1:0] setup_vec, zlen_vec;
  logic              clr_stb;
  logic              fifo_clr_q;
  logic [EP_W-1:0]   clr_ep_q;
  logic [4:0]        unused_wdata;

  assign wr_req       = cpu_wdata[BIT_REQ];
  assign wr_dir       = cpu_wdata[BIT_DIR];
  assign wr_clr       = cpu_wdata[BIT_CLR];
  assign unused_wdata = cpu_wdata[7:3];
  assign clr_stb      = cpu_wr && wr_clr;

  efa_handshake #(.EP_W(EP_W), .CNT_W(CNT_W)) i_hs (
    .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst),
    .wr_stb(cpu_wr), .wr_req(wr_req), .wr_dir(wr_dir),
    .ep_sel(ep_sel), .byte_stb(cpu_byte_stb),
    .req_active(fifo_req), .dir_q(fifo_dir), .xfer_ep(fifo_ep),
    .commit_wr(commit_wr), .commit_rd(commit_rd), .commit_cnt(commit_cnt),
    .rd_done_stb(rd_done_stb), .rd_done_ep(rd_done_ep)
  );

  efa_ep_status #(.EP_W(EP_W)) i_st (
    .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst),
    .sie_ep(sie_ep), .setup_stb(sie_setup_stb), .data_stb(sie_data_stb),
    .zlp_stb(sie_zlp_stb), .rd_done_stb(rd_done_stb), .rd_done_ep(rd_done_ep),
    .clr_stb(clr_stb), .clr_ep(ep_sel),
    .host_in_stb(host_in_stb), .host_in_ep(host_in_ep),
    .setup_vec(setup_vec), .zlen_vec(zlen_vec), .force_tx_err(force_tx_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_clr_q <= 1'b0;
      clr_ep_q   <= '0;
    end else if (usb_rst) begin
      fifo_clr_q <= 1'b0;
      clr_ep_q   <= '0;
    end else begin
      fifo_clr_q <= clr_stb;
      if (clr_stb) clr_ep_q <= ep_sel;
    end
  end

  assign fifo_clr = fifo_clr_q;
  assign clr_ep   = clr_ep_q;

  always_comb begin
    cpu_rdata            = '0;
    cpu_rdata[BIT_REQ]   = fifo_req;
    cpu_rdata[BIT_DIR]   = fifo_dir;
    cpu_rdata[BIT_SETUP] = setup_vec[ep_sel];
    cpu_rdata[BIT_READY] = sie_ready[ep_sel];
    cpu_rdata[BIT_ZLEN]  = zlen_vec[ep_sel];
  end

  AST_BUS_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(usb_rst) |-> (!fifo_req && !fifo_dir && !commit_wr && !commit_rd
                        && !fifo_clr && !force_tx_err && (setup_vec == '0) && (zlen_vec == '0))); // R1
  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_clr && !clr_stb) |=> !fifo_clr); // R8
endmodule

// File: tb/test_ep_fifo_access_ctrl.sv
module test_ep_fifo_access_ctrl;
  localparam int EP_W = 3;
  localparam int CNT_W = 7;
  localparam int NUM_EP = 1 << EP_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usb_rst = 1'b0;
  logic cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic [EP_W-1:0] ep_sel = '0;
  logic cpu_byte_stb = 1'b0;
  logic [EP_W-1:0] sie_ep = '0;
  logic sie_setup_stb = 1'b0, sie_data_stb = 1'b0, sie_zlp_stb = 1'b0;
  logic [NUM_EP-1:0] sie_ready = '0;
  logic host_in_stb = 1'b0;
  logic [EP_W-1:0] host_in_ep = '0;
  logic fifo_req, fifo_dir, commit_wr, commit_rd, fifo_clr, force_tx_err;
  logic [EP_W-1:0] fifo_ep, clr_ep;
  logic [CNT_W-1:0] commit_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit m_setup[NUM_EP];
  bit m_zlen[NUM_EP];
  bit m_pend[NUM_EP];

  always #5 clk = ~clk;

  ep_fifo_access_ctrl #(.EP_W(EP_W), .CNT_W(CNT_W)) i_ep_fifo_access_ctrl (
    .clk(clk), .rst_n(rst_n), .usb_rst(usb_rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .ep_sel(ep_sel), .cpu_byte_stb(cpu_byte_stb), .sie_ep(sie_ep),
    .sie_setup_stb(sie_setup_stb), .sie_data_stb(sie_data_stb), .sie_zlp_stb(sie_zlp_stb),
    .sie_ready(sie_ready), .host_in_stb(host_in_stb), .host_in_ep(host_in_ep),
    .fifo_req(fifo_req), .fifo_dir(fifo_dir), .fifo_ep(fifo_ep), .commit_wr(commit_wr),
    .commit_rd(commit_rd), .commit_cnt(commit_cnt), .fifo_clr(fifo_clr), .clr_ep(clr_ep),
    .force_tx_err(force_tx_err)
  );

  function automatic int exp_cnt(input int n);
    int lim = (1 << CNT_W) - 1;
    return (n > lim) ? lim : n;
  endfunction

  function automatic logic [7:0] exp_status(input int e, input logic rdy);
    return {2'b00, m_zlen[e], rdy, m_setup[e], 3'b000};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr = 1'b1; cpu_wdata = d;
    step();
    cpu_wr = 1'b0; cpu_wdata = '0;
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin
      cpu_byte_stb = 1'b1; step();
    end
    cpu_byte_stb = 1'b0;
  endtask

  task automatic sie(input int kind, input int e);
    sie_ep = EP_W'(e);
    sie_setup_stb = (kind == 0); sie_data_stb = (kind == 1); sie_zlp_stb = (kind == 2);
    step();
    sie_setup_stb = 1'b0; sie_data_stb = 1'b0; sie_zlp_stb = 1'b0;
    if (kind == 0) m_setup[e] = 1'b1;
    else m_setup[e] = 1'b0;
    if (kind == 2) m_zlen[e] = 1'b1;
  endtask

  task automatic host_in(input int e);
    host_in_stb = 1'b1; host_in_ep = EP_W'(e);
    step();
    host_in_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired before the run ended");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int e = 0; e < NUM_EP; e++) begin m_setup[e] = 0; m_zlen[e] = 0; m_pend[e] = 0; end
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 reset status", cpu_rdata, 8'h00);
    chk("R1 reset claim", fifo_req, 0);

    // R11: ready follows the level input
    sie_ready = 8'b0000_0100; ep_sel = 3'd2; #1;
    chk("R11 ready ep2", cpu_rdata[4], 1);
    wr(8'h10);
    chk("R11 write ignored claim", fifo_req, 0);
    chk("R11 ready after write", cpu_rdata[4], 1);
    ep_sel = 3'd3; #1;
    chk("R11 ready ep3", cpu_rdata[4], 0);
    wr(8'hC0);
    chk("R12 upper bits zero", cpu_rdata[7:6], 0);

    // R2 / R6 / R3: write claim, stale re-request, count
    ep_sel = 3'd5;
    wr(8'h03);
    chk("R2 claim", fifo_req, 1);
    chk("R2 claimed ep", fifo_ep, 5);
    chk("R2 dir", fifo_dir, 1);
    bytes(4);
    ep_sel = 3'd1;
    wr(8'h03);
    chk("R6 ep kept", fifo_ep, 5);
    bytes(2);
    wr(8'h01);
    chk("R3 commit_wr", commit_wr, 1);
    chk("R3 count across re-request R6", commit_cnt, exp_cnt(6));
    step();
    chk("R3 single pulse", commit_wr, 0);
    // R5: further toggles give nothing
    wr(8'h03);
    chk("R5 no pulse", commit_wr | commit_rd, 0);
    wr(8'h01);
    chk("R5 no second commit", commit_wr, 0);
    wr(8'h00);
    chk("R7 drop", fifo_req, 0);

    // R4 / R12: read claim clears zero-length flag
    sie(2, 4);
    ep_sel = 3'd4; #1;
    chk("R12 zlen set", cpu_rdata[5], 1);
    wr(8'h01);
    chk("R2 read claim dir", fifo_dir, 0);
    wr(8'h03);
    chk("R4 commit_rd", commit_rd, 1);
    chk("R4 zlen cleared", cpu_rdata[5], 0);
    wr(8'h02);
    chk("R7 drop read", fifo_req, 0);
    chk("R4 single pulse", commit_rd, 0);
    wr(8'h00);
    m_zlen[4] = 0;

    // R3 saturation
    ep_sel = 3'd0;
    wr(8'h03);
    bytes(130);
    wr(8'h01);
    chk("R3 saturated count", commit_cnt, exp_cnt(130));
    wr(8'h00);

    // R8 / R9: flush, not ready
    sie_ready = '0; ep_sel = 3'd6;
    wr(8'h04);
    chk("R8 fifo_clr", fifo_clr, 1);
    chk("R8 clr_ep", clr_ep, 6);
    chk("R8 bit2 reads 0", cpu_rdata[2], 0);
    step();
    chk("R8 single pulse", fifo_clr, 0);
    host_in(3);
    chk("R9 other ep", force_tx_err, 0);
    host_in(6);
    chk("R9 forced", force_tx_err, 1);
    host_in(6);
    chk("R9 only once", force_tx_err, 0);

    // R10: sticky setup flag
    sie(0, 2);
    ep_sel = 3'd2; #1;
    chk("R10 setup set", cpu_rdata[3], 1);
    sie(1, 5);
    chk("R10 other ep keeps", cpu_rdata[3], 1);
    sie(1, 2);
    chk("R10 data clears", cpu_rdata[3], 0);
    sie(0, 1); sie(2, 1);
    ep_sel = 3'd1; #1;
    chk("R10 zlp clears setup", cpu_rdata[3], 0);
    chk("R12 zlp sets zlen", cpu_rdata[5], 1);

    // R1: bus reset from a busy state
    sie(0, 0); sie(2, 0); ep_sel = 3'd0; wr(8'h04); wr(8'h03);
    usb_rst = 1'b1; step(); usb_rst = 1'b0;
    sie_ready = '0; #1;
    chk("R1 status cleared", cpu_rdata, 8'h00);
    chk("R1 claim cleared", fifo_req, 0);
    for (int e = 0; e < NUM_EP; e++) begin
      ep_sel = EP_W'(e); #1;
      chk("R1 all eps cleared", cpu_rdata, 8'h00);
      m_setup[e] = 0; m_zlen[e] = 0; m_pend[e] = 0;
    end
    host_in(0);
    chk("R1 flush pending cleared", force_tx_err, 0);

    // constrained random rounds against the model
    for (int it = 0; it < 400; it++) begin
      int op, e, n;
      op = $urandom % 6;
      e  = $urandom % NUM_EP;
      case (op)
        0: sie($urandom % 3, e);
        1: begin
          sie_ready = NUM_EP'($urandom); ep_sel = EP_W'(e); #1;
          chk("R10 R11 R12 random status", cpu_rdata, exp_status(e, sie_ready[e]));
        end
        2: begin
          ep_sel = EP_W'(e);
          wr(8'h01); wr(8'h03);
          chk("R4 random commit_rd", commit_rd, 1);
          m_zlen[e] = 0;
          wr(8'h00);
        end
        3: begin
          n = $urandom % 20;
          ep_sel = EP_W'(e);
          wr(8'h03); bytes(n); wr(8'h01);
          chk("R3 random count", {commit_wr, 24'b0, commit_cnt}, {1'b1, 24'b0, 7'(exp_cnt(n))});
          wr(8'h00);
        end
        4: begin
          ep_sel = EP_W'(e);
          wr(8'h04);
          chk("R8 random clr_ep", {fifo_clr, clr_ep}, {1'b1, 3'(e)});
          m_pend[e] = 1;
        end
        default: begin
          host_in(e);
          chk("R9 random force", force_tx_err, m_pend[e]);
          m_pend[e] = 0;
        end
      endcase
    end
    finish_run();
  end
endmodule